// File: doc/BRIEF.md
# Memory Sizing and Map Initializer

This block is a start-up sequencer. It leaves reset, proves that the page-translation map works as ordinary storage, and then discovers which physical pages of main memory answer correctly. Good pages are packed into consecutive map entries from entry 0, the other entries are marked vacant, and every usable page is cleared before the block reports its outcome.

It owns two ports. The map port is a synchronous RAM interface whose read data returns one cycle after the address, bit-inverted with respect to what was written. The memory port moves four words per access. A fetch returns its data together with a fault bit one cycle after the request. Sizing writes a tag quadword into every page from the top page downward, then checks the tags sweeping upward. A bank that aliases onto a lower bank therefore reads back a lower page's tag and is rejected. No page that is really present gets damaged. The outcome is a one-cycle done strobe or a held failure flag with a code, plus the number of good pages.

Top module: `mem_size_init`

## Requirements
- R1: After reset the map is tested in two ascending passes over every entry. Pass one writes each index XOR all ones, pass two writes each index XOR zero. Each entry is written, then read back and checked, before the next entry is written.
- R2: A map readback that differs from the bitwise inverse of the value written stops the block with `initFail` high and `failCode` = 102. No memory access is made and `initDone` never rises.
- R3: After the map test every physical page is written at word offset 0, from the highest page down to page 0. Word 0 holds the page number, word 1 holds 0o326, word 2 holds 0o134000 and word 3 holds 0. Word k sits at bits 16k+15:16k of the store data.
- R4: Pages are then fetched at word offset 0 in ascending order. A page is good only if the low page-number bits of word 0 equal its number and words 1 to 3 hold their constants.
- R5: A fetch that returns the fault bit rejects that page even when the data matches. The sweep still goes on to the next page.
- R6: Each good page is written into the next unused map entry, starting at entry 0, with the page number as data. Each one raises `goodPages` by one. A rejected page consumes no entry.
- R7: Once the sweep ends, every map entry that was not assigned is written with 0o60000, in ascending order.
- R8: Every word of every assigned page is then cleared with all-zero four-word stores. The order runs from the last assigned entry down to entry 0, and within a page from the highest quadword down. The physical page is taken from the inverted map readback.
- R9: If fewer than 256 good pages were found, the block stops after clearing with `initFail` high and `failCode` = 101. `goodPages` still shows the count.
- R10: On success `initDone` is high for exactly one cycle and `initFail` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; the sequence starts on release |
| mapAddr | output | MAP_AW | Map entry address |
| mapWe | output | 1 | Map write strobe |
| mapWdata | output | WORD_W | Map write data |
| mapRdata | input | WORD_W | Map read data, inverted, one cycle after the address |
| memAddr | output | PAGE_W+OFF_W | Word address of the quadword (low two bits zero) |
| memWe | output | 1 | Quadword store strobe |
| memRe | output | 1 | Quadword fetch strobe |
| memWdata | output | 4*WORD_W | Store data, word 0 in the low bits |
| memRdata | input | 4*WORD_W | Fetch data, one cycle after `memRe` |
| memFault | input | 1 | Fault for the fetch, valid with `memRdata` |
| initDone | output | 1 | One-cycle success strobe |
| initFail | output | 1 | Held failure flag |
| failCode | output | 8 | Failure code (101 or 102) |
| goodPages | output | PAGE_W+1 | Number of good pages found |

## Verification
In the sweep check cycle, a tag comparison that matches and a fetch fault can arrive together, and the fault must win. The bench provokes this with a page that stores and returns a perfect tag but always raises the fault bit. The result is judged by requiring that the next good page takes the entry the faulty page would have used. Alias banks, absent ranges and a page with a corrupted constant mark the other rejection paths. A stuck map bit and a shortage of pages drive the two failure codes.

// File: rtl/mem_size_init_pkg.sv
package mem_size_init_pkg;

  localparam logic [7:0] CODE_SMALL = 8'd101;
  localparam logic [7:0] CODE_MAP   = 8'd102;

  typedef enum logic [2:0] {
    MS_NONE, MS_TEST_WR, MS_TEST_RD, MS_ASSIGN, MS_VACANT, MS_ZERO_RD
  } mapSel_e;

  typedef enum logic [1:0] {
    MM_NONE, MM_FILL, MM_FETCH, MM_ZERO
  } memSel_e;

  typedef enum logic [3:0] {
    S_START, S_MT_WR, S_MT_RD, S_MT_CMP, S_FILL, S_FETCH, S_CHECK,
    S_VACANT, S_ZCHK, S_ZRD, S_ZCAP, S_ZST, S_DONE, S_IDLE, S_FAIL
  } phase_e;

  typedef struct packed {
    mapSel_e mapSel;
    memSel_e memSel;
    logic    idxInc;
    logic    passSet;
    logic    pageSetTop;
    logic    pageDec;
    logic    pageInc;
    logic    zLoad;
    logic    zDec;
    logic    physCapture;
    logic    quadLoad;
    logic    quadDec;
  } strobe_t;

  typedef struct packed {
    logic idxLast;
    logic passOne;
    logic mapOk;
    logic pageFirst;
    logic pageLast;
    logic mapFull;
    logic zEmpty;
    logic quadZero;
    logic countLow;
  } status_t;

endpackage

// File: rtl/mem_size_init_dp.sv
module mem_size_init_dp
  import mem_size_init_pkg::*;
#(
  parameter int PAGE_W   = 12,
  parameter int MAP_AW   = 14,
  parameter int WORD_W   = 16,
  parameter int OFF_W    = 8,
  parameter int MIN_GOOD = 256,
  parameter logic [WORD_W-1:0] TAG1   = 16'o326,
  parameter logic [WORD_W-1:0] TAG2   = 16'o134000,
  parameter logic [WORD_W-1:0] VACANT = 16'o60000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   ctl,
  output status_t                   sts,
  output logic [MAP_AW-1:0]         mapAddr,
  output logic                      mapWe,
  output logic [WORD_W-1:0]         mapWdata,
  input  logic [WORD_W-1:0]         mapRdata,
  output logic [PAGE_W+OFF_W-1:0]   memAddr,
  output logic                      memWe,
  output logic                      memRe,
  output logic [4*WORD_W-1:0]       memWdata,
  input  logic [4*WORD_W-1:0]       memRdata,
  input  logic                      memFault,
  output logic [PAGE_W:0]           goodPages
);

  localparam int QUAD_W = OFF_W - 2;
  localparam int CNT_W  = PAGE_W + 1;
  localparam int ENT_W  = MAP_AW + 1;

  logic [MAP_AW-1:0] idx;
  logic              passOne;
  logic [PAGE_W-1:0] page;
  logic [ENT_W-1:0]  entry;
  logic [CNT_W-1:0]  count;
  logic [ENT_W-1:0]  zPage;
  logic [PAGE_W-1:0] phys;
  logic [QUAD_W-1:0] quad;

  logic [WORD_W-1:0] testPat;
  logic [WORD_W-1:0] expWord;
  logic [WORD_W-1:0] rdW0, rdW1, rdW2, rdW3;
  logic [WORD_W-PAGE_W-1:0] word0HiUnused;
  logic              pageGood;
  logic              assignHit;
  logic              vacantHit;

  // map test pattern for the current pass
  assign testPat = passOne ? '0 : '1;
  assign expWord = WORD_W'(idx) ^ testPat;

  assign rdW0 = memRdata[WORD_W-1:0];
  assign rdW1 = memRdata[2*WORD_W-1:WORD_W];
  assign rdW2 = memRdata[3*WORD_W-1:2*WORD_W];
  assign rdW3 = memRdata[4*WORD_W-1:3*WORD_W];
  assign word0HiUnused = rdW0[WORD_W-1:PAGE_W];

  assign pageGood = !memFault && (rdW0[PAGE_W-1:0] == page) &&
                    (rdW1 == TAG1) && (rdW2 == TAG2) && (rdW3 == '0);

  assign assignHit = (ctl.mapSel == MS_ASSIGN) && pageGood && !entry[MAP_AW];
  assign vacantHit = (ctl.mapSel == MS_VACANT) && !entry[MAP_AW];

  // map port
  always_comb begin
    mapAddr  = idx;
    mapWe    = 1'b0;
    mapWdata = expWord;
    unique case (ctl.mapSel)
      MS_TEST_WR: mapWe = 1'b1;
      MS_ASSIGN: begin
        mapAddr  = entry[MAP_AW-1:0];
        mapWe    = assignHit;
        mapWdata = WORD_W'(page);
      end
      MS_VACANT: begin
        mapAddr  = entry[MAP_AW-1:0];
        mapWe    = vacantHit;
        mapWdata = VACANT;
      end
      MS_ZERO_RD: mapAddr = zPage[MAP_AW-1:0];
      default: ;
    endcase
  end

  // memory port
  always_comb begin
    memAddr  = {page, {OFF_W{1'b0}}};
    memWe    = 1'b0;
    memRe    = 1'b0;
    memWdata = '0;
    unique case (ctl.memSel)
      MM_FILL: begin
        memWe    = 1'b1;
        memWdata = {{WORD_W{1'b0}}, TAG2, TAG1, WORD_W'(page)};
      end
      MM_FETCH: memRe = 1'b1;
      MM_ZERO: begin
        memWe   = 1'b1;
        memAddr = {phys, quad, 2'b00};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx     <= '0;
      passOne <= 1'b0;
      page    <= '1;
      entry   <= '0;
      count   <= '0;
      zPage   <= '0;
      phys    <= '0;
      quad    <= '0;
    end else begin
      if (ctl.idxInc)  idx     <= idx + 1'b1;
      if (ctl.passSet) passOne <= 1'b1;
      if (ctl.pageSetTop)   page <= '1;
      else if (ctl.pageDec) page <= page - 1'b1;
      else if (ctl.pageInc) page <= page + 1'b1;
      if (assignHit || vacantHit) entry <= entry + 1'b1;
      if (assignHit) count <= count + 1'b1;
      if (ctl.zLoad)     zPage <= ENT_W'(count);
      else if (ctl.zDec) zPage <= zPage - 1'b1;
      if (ctl.physCapture) phys <= ~mapRdata[PAGE_W-1:0];
      if (ctl.quadLoad)     quad <= '1;
      else if (ctl.quadDec) quad <= quad - 1'b1;
    end
  end

  assign sts.idxLast   = &idx;
  assign sts.passOne   = passOne;
  assign sts.mapOk     = (mapRdata == ~expWord);
  assign sts.pageFirst = (page == '0);
  assign sts.pageLast  = &page;
  assign sts.mapFull   = entry[MAP_AW];
  assign sts.zEmpty    = (zPage == '0);
  assign sts.quadZero  = (quad == '0);
  assign sts.countLow  = (count < CNT_W'(MIN_GOOD));

  assign goodPages = count;

endmodule

// File: rtl/mem_size_init_ctl.sv
module mem_size_init_ctl
  import mem_size_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  status_t    sts,
  output strobe_t    ctl,
  output logic       initDone,
  output logic       initFail,
  output logic [7:0] failCode
);

  phase_e     state, nextState;
  logic [7:0] nextCode;

  always_comb begin
    ctl       = '0;
    nextState = state;
    nextCode  = failCode;
    unique case (state)
      S_START: nextState = S_MT_WR;
      S_MT_WR: begin
        ctl.mapSel = MS_TEST_WR;
        nextState  = S_MT_RD;
      end
      S_MT_RD: begin
        ctl.mapSel = MS_TEST_RD;
        nextState  = S_MT_CMP;
      end
      S_MT_CMP: begin
        if (!sts.mapOk) begin
          nextCode  = CODE_MAP;
          nextState = S_FAIL;
        end else if (sts.idxLast && sts.passOne) begin
          ctl.pageSetTop = 1'b1;
          nextState      = S_FILL;
        end else begin
          ctl.idxInc  = 1'b1;
          ctl.passSet = sts.idxLast;
          nextState   = S_MT_WR;
        end
      end
      S_FILL: begin
        ctl.memSel = MM_FILL;
        if (sts.pageFirst) nextState = S_FETCH;
        else ctl.pageDec = 1'b1;
      end
      S_FETCH: begin
        ctl.memSel = MM_FETCH;
        nextState  = S_CHECK;
      end
      S_CHECK: begin
        ctl.mapSel = MS_ASSIGN;
        if (sts.pageLast) nextState = S_VACANT;
        else begin
          ctl.pageInc = 1'b1;
          nextState   = S_FETCH;
        end
      end
      S_VACANT: begin
        if (sts.mapFull) begin
          ctl.zLoad = 1'b1;
          nextState = S_ZCHK;
        end else ctl.mapSel = MS_VACANT;
      end
      S_ZCHK: begin
        if (!sts.zEmpty) begin
          ctl.zDec  = 1'b1;
          nextState = S_ZRD;
        end else if (sts.countLow) begin
          nextCode  = CODE_SMALL;
          nextState = S_FAIL;
        end else nextState = S_DONE;
      end
      S_ZRD: begin
        ctl.mapSel = MS_ZERO_RD;
        nextState  = S_ZCAP;
      end
      S_ZCAP: begin
        ctl.physCapture = 1'b1;
        ctl.quadLoad    = 1'b1;
        nextState       = S_ZST;
      end
      S_ZST: begin
        ctl.memSel = MM_ZERO;
        if (sts.quadZero) nextState = S_ZCHK;
        else ctl.quadDec = 1'b1;
      end
      S_DONE:  nextState = S_IDLE;
      S_IDLE:  nextState = S_IDLE;
      S_FAIL:  nextState = S_FAIL;
      default: nextState = S_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_START;
      failCode <= '0;
    end else begin
      state    <= nextState;
      failCode <= nextCode;
    end
  end

  assign initDone = (state == S_DONE);
  assign initFail = (state == S_FAIL);

endmodule

// File: rtl/mem_size_init.sv
module mem_size_init
  import mem_size_init_pkg::*;
#(
  parameter int PAGE_W   = 12,
  parameter int MAP_AW   = 14,
  parameter int WORD_W   = 16,
  parameter int OFF_W    = 8,
  parameter int MIN_GOOD = 256
) (
  input  logic                    clk,
  input  logic                    rstN,
  output logic [MAP_AW-1:0]       mapAddr,
  output logic                    mapWe,
  output logic [WORD_W-1:0]       mapWdata,
  input  logic [WORD_W-1:0]       mapRdata,
  output logic [PAGE_W+OFF_W-1:0] memAddr,
  output logic                    memWe,
  output logic                    memRe,
  output logic [4*WORD_W-1:0]     memWdata,
  input  logic [4*WORD_W-1:0]     memRdata,
  input  logic                    memFault,
  output logic                    initDone,
  output logic                    initFail,
  output logic [7:0]              failCode,
  output logic [PAGE_W:0]         goodPages
);

  strobe_t ctl;
  status_t sts;

  mem_size_init_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .sts      (sts),
    .ctl      (ctl),
    .initDone (initDone),
    .initFail (initFail),
    .failCode (failCode)
  );

  mem_size_init_dp #(
    .PAGE_W   (PAGE_W),
    .MAP_AW   (MAP_AW),
    .WORD_W   (WORD_W),
    .OFF_W    (OFF_W),
    .MIN_GOOD (MIN_GOOD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sts       (sts),
    .mapAddr   (mapAddr),
    .mapWe     (mapWe),
    .mapWdata  (mapWdata),
    .mapRdata  (mapRdata),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memRe     (memRe),
    .memWdata  (memWdata),
    .memRdata  (memRdata),
    .memFault  (memFault),
    .goodPages (goodPages)
  );

endmodule

// File: rtl/mem_size_chk.sv
module mem_size_chk #(
  parameter int OFF_W  = 8,
  parameter int WORD_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                initDone,
  input logic                initFail,
  input logic [7:0]          failCode,
  input logic                mapWe,
  input logic                memWe,
  input logic                memRe,
  input logic [OFF_W-1:0]    storeOff,
  input logic [4*WORD_W-1:0] memWdata
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> !initDone);

  // R2
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(initDone && initFail));

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    initFail |=> (initFail && $stable(failCode)));

  // R2
  fail_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    initFail |-> (failCode == 8'd101 || failCode == 8'd102));

  // R2
  quiet_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    initFail |-> !(mapWe || memWe || memRe));

  // R8
  zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && storeOff != '0) |-> (memWdata == '0));

  // R4
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

endmodule

bind mem_size_init mem_size_chk #(
  .OFF_W  (OFF_W),
  .WORD_W (WORD_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .initDone (initDone),
  .initFail (initFail),
  .failCode (failCode),
  .mapWe    (mapWe),
  .memWe    (memWe),
  .memRe    (memRe),
  .storeOff (memAddr[OFF_W-1:0]),
  .memWdata (memWdata)
);

// File: tb/test_mem_size_init.sv
`timescale 1ns/1ps
module test_mem_size_init;

  localparam int PW    = 9;
  localparam int MW    = 10;
  localparam int OW    = 5;
  localparam int WW    = 16;
  localparam int MINP  = 256;
  localparam int NPAGE = 1 << PW;
  localparam int NMAP  = 1 << MW;
  localparam int NQUAD = 1 << (OW - 2);
  localparam int ALIAS_LO = 480;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [MW-1:0]    mapAddr;
  logic             mapWe;
  logic [WW-1:0]    mapWdata;
  logic [WW-1:0]    mapRdata;
  logic [PW+OW-1:0] memAddr;
  logic             memWe, memRe;
  logic [4*WW-1:0]  memWdata;
  logic [4*WW-1:0]  memRdata;
  logic             memFault;
  logic             initDone, initFail;
  logic [7:0]       failCode;
  logic [PW:0]      goodPages;

  mem_size_init #(.PAGE_W(PW), .MAP_AW(MW), .WORD_W(WW), .OFF_W(OW), .MIN_GOOD(MINP))
  i_mem_size_init (
    .clk(clk), .rstN(rstN),
    .mapAddr(mapAddr), .mapWe(mapWe), .mapWdata(mapWdata), .mapRdata(mapRdata),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .memRdata(memRdata), .memFault(memFault),
    .initDone(initDone), .initFail(initFail), .failCode(failCode), .goodPages(goodPages)
  );

  // model configuration
  int cfgAbsLo = -1, cfgAbsHi = -1, cfgFault = -1, cfgCorrupt = -1;
  int cfgStuckE = -1, cfgStuckB = 0;
  bit cfgAlias = 1'b0;

  typedef struct { logic [MW-1:0] a; logic [WW-1:0] d; string req; } mapItem_t;
  typedef struct { bit wr; logic [PW+OW-1:0] a; logic [4*WW-1:0] d; string req; } memItem_t;
  mapItem_t mapQ[$];
  memItem_t memQ[$];
  mapItem_t mIt;
  memItem_t qIt;

  int total = 0, bad = 0, doneCycles = 0, cycles = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic bit absentPage(input int p);
    return (p >= cfgAbsLo) && (p <= cfgAbsHi);
  endfunction

  function automatic int physOf(input int p);
    return (cfgAlias && p >= ALIAS_LO) ? p - 256 : p;
  endfunction

  function automatic bit goodPage(input int p);
    return !absentPage(p) && p != cfgFault && p != cfgCorrupt &&
           !(cfgAlias && p >= ALIAS_LO);
  endfunction

  function automatic logic [WW-1:0] stuckApply(input logic [MW-1:0] a, input logic [WW-1:0] v);
    logic [WW-1:0] r;
    r = v;
    if (cfgStuckE >= 0 && int'(a) == cfgStuckE) r[cfgStuckB] = 1'b0;
    return r;
  endfunction

  // map and memory models
  logic [WW-1:0]   mapArr [NMAP];
  logic [4*WW-1:0] tagArr [NPAGE];
  int mPage;

  always @(posedge clk) begin
    if (mapWe) mapArr[mapAddr] <= stuckApply(mapAddr, ~mapWdata);
    mapRdata <= mapArr[mapAddr];
    mPage = int'(memAddr[PW+OW-1:OW]);
    if (memWe && memAddr[OW-1:0] == '0 && !absentPage(mPage))
      tagArr[physOf(mPage)] <= memWdata;
    if (memRe) begin
      memFault <= absentPage(mPage) || mPage == cfgFault;
      memRdata <= tagArr[physOf(mPage)] ^
                  ((mPage == cfgCorrupt) ? 64'h0000_0000_0001_0000 : 64'h0);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (initDone) doneCycles++;
      if (mapWe) begin
        if (mapQ.size() == 0)
          check(1'b0, "R1", "unexpected map write", 64'({mapAddr, mapWdata}), 64'h0);
        else begin
          mIt = mapQ.pop_front();
          check(mapAddr == mIt.a && mapWdata == mIt.d, mIt.req, "map write",
                64'({mapAddr, mapWdata}), 64'({mIt.a, mIt.d}));
        end
      end
      if (memWe || memRe) begin
        if (memQ.size() == 0)
          check(1'b0, "R3", "unexpected memory access", 64'({memWe, memAddr}), 64'h0);
        else begin
          qIt = memQ.pop_front();
          check(memWe == qIt.wr && memAddr == qIt.a && (!qIt.wr || memWdata == qIt.d),
                qIt.req, "memory access", 64'({memWe, memAddr}), 64'({qIt.wr, qIt.a}));
          if (qIt.wr && memWdata != qIt.d)
            check(1'b0, qIt.req, "store data", memWdata, qIt.d);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: got %0d cycles expected completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // expected event builder
  task automatic buildExpect(output int expGood);
    int goodList[$];
    int entry;
    bit mapBad;
    logic [WW-1:0] d;
    mapQ.delete();
    memQ.delete();
    mapBad = 1'b0;
    for (int pass = 0; pass < 2 && !mapBad; pass++) begin
      for (int i = 0; i < NMAP && !mapBad; i++) begin
        d = WW'(i) ^ ((pass == 0) ? 16'hFFFF : 16'h0000);
        mapQ.push_back('{a: MW'(i), d: d, req: "R1"});
        if (cfgStuckE == i && d[cfgStuckB] == 1'b0) mapBad = 1'b1;
      end
    end
    if (mapBad) begin
      expGood = -1;
      return;
    end
    for (int p = NPAGE - 1; p >= 0; p--)
      memQ.push_back('{wr: 1'b1, a: (PW+OW)'(p << OW),
                       d: {16'h0, 16'o134000, 16'o326, WW'(p)}, req: "R3"});
    entry = 0;
    for (int p = 0; p < NPAGE; p++) begin
      memQ.push_back('{wr: 1'b0, a: (PW+OW)'(p << OW), d: '0,
                       req: (p == cfgFault) ? "R5" : "R4"});
      if (goodPage(p)) begin
        mapQ.push_back('{a: MW'(entry), d: WW'(p), req: "R6"});
        goodList.push_back(p);
        entry++;
      end
    end
    for (int e = entry; e < NMAP; e++)
      mapQ.push_back('{a: MW'(e), d: 16'o60000, req: "R7"});
    for (int v = goodList.size() - 1; v >= 0; v--)
      for (int q = NQUAD - 1; q >= 0; q--)
        memQ.push_back('{wr: 1'b1, a: (PW+OW)'((goodList[v] << OW) + q * 4),
                         d: '0, req: "R8"});
    expGood = goodList.size();
  endtask

  task automatic runCase(input int absLo, input int absHi, input int faultPg,
                         input int corruptPg, input bit aliasOn,
                         input int stuckE, input int stuckB);
    int expGood;
    bit finished;
    cfgAbsLo = absLo; cfgAbsHi = absHi; cfgFault = faultPg; cfgCorrupt = corruptPg;
    cfgAlias = aliasOn; cfgStuckE = stuckE; cfgStuckB = stuckB;
    buildExpect(expGood);
    doneCycles = 0;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check(initDone == 1'b0, "R10", "done in reset", 64'(initDone), 64'h0);
    check(initFail == 1'b0, "R2", "fail in reset", 64'(initFail), 64'h0);
    check(mapWe == 1'b0, "R1", "map write in reset", 64'(mapWe), 64'h0);
    check(!memWe && !memRe, "R3", "memory access in reset", 64'({memWe, memRe}), 64'h0);
    check(goodPages == '0, "R6", "count in reset", 64'(goodPages), 64'h0);
    rstN = 1'b1;
    finished = 1'b0;
    for (int c = 0; c < 60000 && !finished; c++) begin
      @(negedge clk);
      if (initDone || initFail) finished = 1'b1;
    end
    check(finished, "R10", "sequence completion", 64'(finished), 64'h1);
    repeat (5) @(negedge clk);
    if (expGood < 0) begin
      check(initFail && failCode == 8'd102, "R2", "map fail code", 64'(failCode), 64'd102);
      check(mapQ.size() == 0, "R2", "map writes up to the bad entry", 64'(mapQ.size()), 64'h0);
      check(memQ.size() == 0, "R2", "no memory activity", 64'(memQ.size()), 64'h0);
      check(doneCycles == 0, "R2", "done after map fail", 64'(doneCycles), 64'h0);
    end else if (expGood < MINP) begin
      check(initFail && failCode == 8'd101, "R9", "small memory code", 64'(failCode), 64'd101);
      check(int'(goodPages) == expGood, "R9", "count on failure", 64'(goodPages), 64'(expGood));
      check(memQ.size() == 0, "R8", "all pages cleared", 64'(memQ.size()), 64'h0);
      check(doneCycles == 0, "R9", "done after small fail", 64'(doneCycles), 64'h0);
    end else begin
      check(doneCycles == 1, "R10", "done pulse width", 64'(doneCycles), 64'h1);
      check(!initFail, "R10", "fail on success", 64'(initFail), 64'h0);
      check(int'(goodPages) == expGood, "R6", "good page count", 64'(goodPages), 64'(expGood));
      check(mapQ.size() == 0, "R7", "all map writes seen", 64'(mapQ.size()), 64'h0);
      check(memQ.size() == 0, "R8", "all stores seen", 64'(memQ.size()), 64'h0);
    end
  endtask

  initial begin
    int ent;
    // holes, a faulting page with a correct tag, a corrupt constant, an alias bank
    runCase(40, 47, 100, 60, 1'b1, -1, 0);
    ent = 0;
    for (int p = 0; p < 101; p++) if (goodPage(p)) ent++;
    // R5: the page after the faulting one takes the entry it would have used
    check((~mapArr[ent]) == 16'd101, "R5", "entry after fault page",
          64'(~mapArr[ent]), 64'd101);
    check((~mapArr[ent-1]) == 16'd99, "R5", "entry before fault page",
          64'(~mapArr[ent-1]), 64'd99);
    // stuck map bit
    runCase(-1, -1, -1, -1, 1'b0, 300, 3);
    // too few pages
    runCase(200, NPAGE - 1, -1, -1, 1'b0, -1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule